// File: doc/BRIEF.md
# Virtual Interrupt List-Register Control Block

This block is the hypervisor-facing register file of a virtualized interrupt controller CPU interface. A hypervisor uses it to load pending virtual interrupts into a configurable set of list registers. It also programs a control word, an active-priorities word, and a virtual-machine control word that carries the guest's binary points, priority mask and interface control bits. Two read-only bitmaps are derived from the list registers. The first marks entries that are free to be reused. The second marks entries whose retirement should raise an end-of-interrupt maintenance event. Each bitmap is split across two 32-bit words so that up to 64 entries can be reported.

Access is through a simple register bus with a word address, a read strobe, a write strobe and 32-bit data. Writes take effect at the clock edge on which the strobe is sampled. Read data is registered: it appears one cycle after the read strobe and holds until the next read. The block also drives a running-priority output, which is derived from the lowest set bit of the active-priorities word.

The register offsets are as follows:

| Offset | Register |
|---|---|
| 0x000 | Control |
| 0x004 | Type |
| 0x008 | VM control |
| 0x00C | Active priorities |
| 0x020 / 0x024 | End-of-interrupt bitmap, low word / high word |
| 0x030 / 0x034 | Free-entry bitmap, low word / high word |
| `LR_BASE` + 4·n | List register n |

Top module: `vif_lr_ctrl`

## Requirements
- R1: After reset the following hold:
  - Every list register, the control word and the active-priorities word read as zero.
  - The VM control word reads with its binary point equal to `MIN_BP`, its aliased binary point equal to `MIN_ABP`, and all other fields zero.
  - `run_prio` is 0xFF.
- R2: A write to list register n (address `LR_BASE` + 4·n, with n < `NUM_LR`) stores `bus_wdata & LR_WMASK`, and a later read returns that value. List register fields are: state at bits [`STATE_LSB`+1:`STATE_LSB`] (0 = invalid), hardware flag at bit `HW_BIT`, and EOI-request flag at bit `EOI_BIT`.
- R3: Bit n of the free-entry bitmap is 1 exactly when entry n has state 0 and either its hardware flag is 1 or its EOI-request flag is 0.
- R4: Bit n of the end-of-interrupt bitmap is 1 exactly when entry n has state 0, its hardware flag is 0 and its EOI-request flag is 1.
- R5: For each bitmap, the low word (0x020 or 0x030) carries entries 0 to 31 and the high word (0x024 or 0x034) carries entries 32 to 63. Bits for entries at or above `NUM_LR` read as zero.
- R6: The type word (0x004) returns `NUM_LR`-1 in [5:0], `PRE_BITS`-1 in [10:8] and (6 - `MIN_BP`) in [14:12], with all other bits zero.
- R7: In a write to the VM control word (0x008), the binary point is taken from [10:8] and the aliased binary point from [14:12]. Each is stored raised to `MIN_BP` or `MIN_ABP` if the written value is smaller. A read returns the stored values at the same positions.
- R8: The VM control word keeps an 8-bit priority mask. A write loads it from `bus_wdata[4:0]` shifted left by 3, and a read returns its bits 7:3 in [4:0]. The control bits sit at [25:16] and read back as written.
- R9: A read of a list-register address whose index is `NUM_LR` or higher, or whose address is not word aligned, returns zero. A write to such an address changes no register.
- R10: A write to the control word (0x000) stores `bus_wdata & CTL_WMASK`.
- R11: A read of an unmapped offset returns zero, and a write to one changes no register.
- R12: `run_prio` equals 8·i, where i is the lowest set bit of the active-priorities word (0x00C). It is 0xFF when that word is zero, and it follows the stored word from the cycle after the write.
- R13: `bus_rdata` updates only in the cycle after `bus_rd` is sampled, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| run_prio | output | 8 | Running priority from the active-priorities word |

## Verification
The bench loads entries that cover every combination of state, hardware flag and EOI-request flag. A design that mixed up the two bitmap rules would then report a hardware-backed entry as needing maintenance, or report an entry as both free and needing maintenance. It also writes to indices just past the implemented count and to the high bitmap word. An off-by-one bound would accept a write to entry `NUM_LR`, or would leak ghost bits above the count. Binary-point writes below, at and above the floor, together with a full priority mask, expose a missing clamp or a mask shifted by the wrong amount. Active-priority patterns with a single low bit, a single high bit, several bits and no bits catch an encoder that picks the highest bit or never returns to idle.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    // register offsets of the fixed part of the map
    localparam int OFS_CTL    = 'h000;
    localparam int OFS_TYPE   = 'h004;
    localparam int OFS_VMC    = 'h008;
    localparam int OFS_APR    = 'h00C;
    localparam int OFS_EOI_LO = 'h020;
    localparam int OFS_EOI_HI = 'h024;
    localparam int OFS_EMP_LO = 'h030;
    localparam int OFS_EMP_HI = 'h034;

    // list-register window: 64 word slots
    localparam int LR_SLOTS   = 64;
    localparam int LR_IDX_W   = 6;
    localparam int LR_SPAN    = LR_SLOTS * 4;

    // raise a 3-bit binary point to its floor
    function automatic logic [2:0] bp_floor(input logic [2:0] val, input logic [2:0] floor_v);
        return (val < floor_v) ? floor_v : val;
    endfunction

endpackage

// File: rtl/vlr_lr_status.sv
module vlr_lr_status #(
    parameter int NUM_LR    = 4,
    parameter int STATE_LSB = 28,
    parameter int HW_BIT    = 31,
    parameter int EOI_BIT   = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LR-1:0][31:0] lr_i,
    output logic [63:0]            empty_o,
    output logic [63:0]            eoi_o
);
    for (genvar g = 0; g < vlr_pkg::LR_SLOTS; g++) begin : g_slot
        if (g < NUM_LR) begin : g_impl
            logic idle_st;
            logic hw_f;
            logic eoi_f;
            assign idle_st    = (lr_i[g][STATE_LSB+1:STATE_LSB] == 2'b00);
            assign hw_f       = lr_i[g][HW_BIT];
            assign eoi_f      = lr_i[g][EOI_BIT];
            assign empty_o[g] = idle_st & (hw_f | ~eoi_f);
            assign eoi_o[g]   = idle_st & ~hw_f & eoi_f;
        end else begin : g_pad
            assign empty_o[g] = 1'b0;
            assign eoi_o[g]   = 1'b0;
        end
    end

    // R3 R4: an entry is never both free and awaiting maintenance
    map_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o & eoi_o) == 64'd0);

    // R5: a slot above the implemented count never reports
    if (NUM_LR < vlr_pkg::LR_SLOTS) begin : g_pad_chk
        // R5
        pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (empty_o[63:NUM_LR] == '0) && (eoi_o[63:NUM_LR] == '0));
    end
endmodule

// File: rtl/vlr_apr_prio.sv
module vlr_apr_prio #(
    parameter int APR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [APR_W-1:0] apr_i,
    output logic [7:0]       prio_o
);
    localparam logic [7:0] IDLE = 8'hFF;
    localparam int         STEP = 256 / APR_W;

    always_comb begin
        prio_o = IDLE;
        for (int i = APR_W - 1; i >= 0; i--) begin
            if (apr_i[i]) prio_o = 8'(i * STEP);
        end
    end

    // R12
    idle_iff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apr_i == '0) == (prio_o == IDLE));

    // R12: the reported group's bit is set
    grp_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_o != IDLE) |-> apr_i[prio_o / 8'(STEP)]);
endmodule

// File: rtl/vlr_rd_mux.sv
module vlr_rd_mux #(
    parameter int ADDR_W = 12,
    parameter int NUM_LR = 4
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic                               lr_ok_i,
    input  logic [vlr_pkg::LR_IDX_W-1:0]       lr_idx_i,
    input  logic [31:0]                        ctl_i,
    input  logic [31:0]                        type_i,
    input  logic [31:0]                        vmc_i,
    input  logic [31:0]                        apr_i,
    input  logic [63:0]                        empty_i,
    input  logic [63:0]                        eoi_i,
    input  logic [NUM_LR-1:0][31:0]            lr_i,
    output logic [31:0]                        rdata_o
);
    import vlr_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_TYPE   = ADDR_W'(OFS_TYPE);
    localparam logic [ADDR_W-1:0] A_VMC    = ADDR_W'(OFS_VMC);
    localparam logic [ADDR_W-1:0] A_APR    = ADDR_W'(OFS_APR);
    localparam logic [ADDR_W-1:0] A_EOI_LO = ADDR_W'(OFS_EOI_LO);
    localparam logic [ADDR_W-1:0] A_EOI_HI = ADDR_W'(OFS_EOI_HI);
    localparam logic [ADDR_W-1:0] A_EMP_LO = ADDR_W'(OFS_EMP_LO);
    localparam logic [ADDR_W-1:0] A_EMP_HI = ADDR_W'(OFS_EMP_HI);

    logic [31:0] lr_word;

    always_comb begin
        lr_word = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (lr_idx_i == LR_IDX_W'(i)) lr_word = lr_i[i];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (lr_ok_i) begin
            rdata_o = lr_word;
        end else begin
            unique case (addr_i)
                A_CTL:    rdata_o = ctl_i;
                A_TYPE:   rdata_o = type_i;
                A_VMC:    rdata_o = vmc_i;
                A_APR:    rdata_o = apr_i;
                A_EOI_LO: rdata_o = eoi_i[31:0];
                A_EOI_HI: rdata_o = eoi_i[63:32];
                A_EMP_LO: rdata_o = empty_i[31:0];
                A_EMP_HI: rdata_o = empty_i[63:32];
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/vif_lr_ctrl.sv
module vif_lr_ctrl #(
    parameter int          NUM_LR    = 4,
    parameter int          ADDR_W    = 12,
    parameter int          LR_BASE   = 'h100,
    parameter int          STATE_LSB = 28,
    parameter int          HW_BIT    = 31,
    parameter int          EOI_BIT   = 19,
    parameter int          MIN_BP    = 2,
    parameter int          MIN_ABP   = 3,
    parameter int          PRE_BITS  = 5,
    parameter logic [31:0] LR_WMASK  = 32'hFF88_1FFF,
    parameter logic [31:0] CTL_WMASK = 32'hF800_00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        run_prio
);
    import vlr_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_VMC    = ADDR_W'(OFS_VMC);
    localparam logic [ADDR_W-1:0] A_APR    = ADDR_W'(OFS_APR);
    localparam logic [ADDR_W-1:0] LR_LO    = ADDR_W'(LR_BASE);
    localparam logic [ADDR_W-1:0] LR_HI    = ADDR_W'(LR_BASE + LR_SPAN);
    localparam logic [2:0]        BP_MIN3  = 3'(MIN_BP);
    localparam logic [2:0]        ABP_MIN3 = 3'(MIN_ABP);
    localparam logic [LR_IDX_W:0] LR_CNT   = (LR_IDX_W + 1)'(NUM_LR);
    localparam logic [31:0]       TYPE_WORD = {16'd0, 1'b0, 3'(6 - MIN_BP), 1'b0,
                                               3'(PRE_BITS - 1), 2'b00, 6'(NUM_LR - 1)};

    typedef struct packed {
        logic [31:0]            ctl;
        logic [31:0]            apr;
        logic [9:0]             vctrl;
        logic [2:0]             bp;
        logic [2:0]             abp;
        logic [7:0]             pmask;
        logic [NUM_LR-1:0][31:0] lr;
        logic [31:0]            rdata;
    } st_t;

    st_t s_d, s_q;

    // list-register window decode
    logic [ADDR_W-1:0]   lr_off;
    logic                lr_zone;
    logic [LR_IDX_W-1:0] lr_idx;
    logic                lr_ok;

    assign lr_off  = bus_addr - LR_LO;
    assign lr_zone = (bus_addr >= LR_LO) && (bus_addr < LR_HI);
    assign lr_idx  = lr_off[LR_IDX_W+1:2];
    assign lr_ok   = lr_zone && (lr_off[1:0] == 2'b00) && ({1'b0, lr_idx} < LR_CNT);

    // derived views
    logic [63:0] empty_map;
    logic [63:0] eoi_map;
    logic [31:0] vmc_word;
    logic [31:0] rd_next;

    assign vmc_word = {6'd0, s_q.vctrl, 1'b0, s_q.abp, 1'b0, s_q.bp, 3'd0, s_q.pmask[7:3]};

    vlr_lr_status #(
        .NUM_LR   (NUM_LR),
        .STATE_LSB(STATE_LSB),
        .HW_BIT   (HW_BIT),
        .EOI_BIT  (EOI_BIT)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .lr_i   (s_q.lr),
        .empty_o(empty_map),
        .eoi_o  (eoi_map)
    );

    vlr_apr_prio #(
        .APR_W(32)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .apr_i (s_q.apr),
        .prio_o(run_prio)
    );

    vlr_rd_mux #(
        .ADDR_W(ADDR_W),
        .NUM_LR(NUM_LR)
    ) u_rdmux (
        .addr_i  (bus_addr),
        .lr_ok_i (lr_ok),
        .lr_idx_i(lr_idx),
        .ctl_i   (s_q.ctl),
        .type_i  (TYPE_WORD),
        .vmc_i   (vmc_word),
        .apr_i   (s_q.apr),
        .empty_i (empty_map),
        .eoi_i   (eoi_map),
        .lr_i    (s_q.lr),
        .rdata_o (rd_next)
    );

    always_comb begin
        s_d = s_q;
        if (bus_wr) begin
            if (lr_ok) begin
                for (int i = 0; i < NUM_LR; i++) begin
                    if (lr_idx == LR_IDX_W'(i)) s_d.lr[i] = bus_wdata & LR_WMASK;
                end
            end else if (bus_addr == A_CTL) begin
                s_d.ctl = bus_wdata & CTL_WMASK;
            end else if (bus_addr == A_VMC) begin
                s_d.vctrl = bus_wdata[25:16];
                s_d.abp   = bp_floor(bus_wdata[14:12], ABP_MIN3);
                s_d.bp    = bp_floor(bus_wdata[10:8], BP_MIN3);
                s_d.pmask = {bus_wdata[4:0], 3'b000};
            end else if (bus_addr == A_APR) begin
                s_d.apr = bus_wdata;
            end
        end
        if (bus_rd) s_d.rdata = rd_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.bp  <= BP_MIN3;
            s_q.abp <= ABP_MIN3;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;

    // R7
    bp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.bp >= BP_MIN3) && (s_q.abp >= ABP_MIN3));

    // R8
    pmask_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pmask[2:0] == 3'b000);

    // R9
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && lr_zone && !lr_ok) |=> (bus_rdata == 32'd0));

    // R9
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lr_zone && !lr_ok) |=> (s_q.lr == $past(s_q.lr)));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/vif_lr_ctrl_tb.sv
`timescale 1ns/1ps
module vif_lr_ctrl_tb;
    localparam int NLR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  run_prio;

    int checks = 0;
    int fails  = 0;
    bit live   = 1'b0;
    bit done   = 1'b0;

    // behavioural model
    logic [31:0] m_lr [64];
    logic [31:0] m_ctl, m_apr;
    int          m_bp, m_abp, m_pm, m_vc;

    always #10 clk = ~clk;

    vif_lr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .run_prio(run_prio)
    );

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endfunction

    function automatic bit is_free(logic [31:0] v);
        return (v[29:28] == 2'b00) && (v[31] || !v[19]);
    endfunction

    function automatic bit is_eoi(logic [31:0] v);
        return (v[29:28] == 2'b00) && !v[31] && v[19];
    endfunction

    function automatic logic [31:0] exp_read(int a);
        logic [31:0] r = 0;
        if (a >= 'h100 && a < 'h200) begin
            if ((a % 4) == 0 && ((a - 'h100) / 4) < NLR) r = m_lr[(a - 'h100) / 4];
            return r;
        end
        case (a)
            'h000: r = m_ctl;
            'h004: r = (32'(6 - 2) << 12) | (32'(5 - 1) << 8) | 32'(NLR - 1);
            'h008: r = (32'(m_vc) << 16) | (32'(m_abp) << 12) | (32'(m_bp) << 8) | 32'(m_pm >> 3);
            'h00C: r = m_apr;
            'h020, 'h024, 'h030, 'h034: begin
                for (int k = 0; k < 32; k++) begin
                    int n = k + ((a % 8) != 0 ? 32 : 0);
                    if (n < NLR) r[k] = (a < 'h030) ? is_eoi(m_lr[n]) : is_free(m_lr[n]);
                end
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] exp_prio();
        for (int i = 0; i < 32; i++) if (m_apr[i]) return 8'(i * 8);
        return 8'hFF;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 'h100 && a < 'h200) begin
            if ((a % 4) == 0 && ((a - 'h100) / 4) < NLR) m_lr[(a - 'h100) / 4] = d & 32'hFF88_1FFF;
        end else begin
            case (a)
                'h000: m_ctl = d & 32'hF800_00FF;
                'h008: begin
                    m_vc  = int'(d[25:16]);
                    m_abp = (int'(d[14:12]) < 3) ? 3 : int'(d[14:12]);
                    m_bp  = (int'(d[10:8]) < 2) ? 2 : int'(d[10:8]);
                    m_pm  = int'(d[4:0]) << 3;
                end
                'h00C: m_apr = d;
                default: ;
            endcase
        end
    endtask

    task automatic rd(int a, string req);
        @(negedge clk);
        bus_addr = 12'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, exp_read(a));
    endtask

    // running priority compared on every clock
    always @(negedge clk) begin
        if (live) begin
            #1;
            chk("R12", {24'd0, run_prio}, {24'd0, exp_prio()});
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        for (int i = 0; i < 64; i++) m_lr[i] = 0;
        m_ctl = 0; m_apr = 0; m_bp = 2; m_abp = 3; m_pm = 0; m_vc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R1 reset state, R6 type word
        rd('h000, "R1"); rd('h008, "R1"); rd('h00C, "R1");
        for (int i = 0; i < NLR; i++) rd('h100 + 4 * i, "R1");
        rd('h030, "R3"); rd('h020, "R4"); rd('h004, "R6");

        // R2 masked list-register writes covering flag combinations
        wr('h100, 32'hFFFF_FFFF);
        wr('h104, 32'h0008_0025);
        wr('h108, 32'h8008_0011);
        wr('h10C, 32'h1000_0001);
        for (int i = 0; i < NLR; i++) rd('h100 + 4 * i, "R2");
        rd('h030, "R3"); rd('h020, "R4");
        rd('h034, "R5"); rd('h024, "R5");

        // R3 R4 hardware-only, bare, and retired entries
        wr('h100, 32'h8000_0000);
        wr('h10C, 32'h0008_0000);
        rd('h030, "R3"); rd('h020, "R4");

        // R9 out-of-range and unaligned list-register accesses
        wr('h110, 32'hFFFF_FFFF);
        wr('h1A0, 32'h0008_0000);
        wr('h105, 32'h0000_0000);
        rd('h110, "R9"); rd('h1FC, "R9"); rd('h106, "R9");
        for (int i = 0; i < NLR; i++) rd('h100 + 4 * i, "R9");
        rd('h034, "R5"); rd('h024, "R5");

        // R10 control mask
        wr('h000, 32'hFFFF_FFFF); rd('h000, "R10");
        wr('h000, 32'h1234_5678); rd('h000, "R10");

        // R7 clamp, R8 priority mask and control bits
        wr('h008, 32'h0000_1000); rd('h008, "R7");
        wr('h008, 32'h03FF_7600); rd('h008, "R7");
        wr('h008, 32'h0000_331F); rd('h008, "R8");
        wr('h008, 32'h0155_2408); rd('h008, "R8");

        // R11 unmapped offsets
        wr('h044, 32'hFFFF_FFFF); wr('h0F0, 32'hFFFF_FFFF);
        rd('h044, "R11"); rd('h0F0, "R11"); rd('h010, "R11");
        rd('h000, "R11"); rd('h008, "R11"); rd('h00C, "R11");

        // R12 active priorities
        wr('h00C, 32'h0000_0008); rd('h00C, "R12");
        wr('h00C, 32'h8000_0000);
        wr('h00C, 32'h0000_0006);
        wr('h00C, 32'h0000_0000);
        wr('h00C, 32'h0001_0001);

        // R13 read data holds without a read strobe
        rd('h000, "R13");
        held = bus_rdata;
        wr('h000, 32'h0000_0000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bus_addr = 12'h004;
            #1 chk("R13", bus_rdata, held);
        end
        rd('h000, "R13");

        repeat (2) @(negedge clk);
        live = 1'b0;
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule